// File: doc/BRIEF.md
# Streaming Hamming ECC generator

This block watches a byte-wide data stream and builds single-error-correcting, double-error-detecting Hamming check codes over fixed-size blocks of it. Each accepted byte folds into a set of running parities. Column parities are taken over groups of bit positions inside each byte. Line parities are taken over the parity of each byte, split by every bit of its position in the block. When the last byte of a block arrives, the finished 24-bit code is written into one of two code registers.

A mode input chooses the layout. In the split layout, two codes are built, each over 256 bytes. In the joined layout, one code is built over 512 bytes. After the final code of the chosen layout is stored, the block freezes and ignores further bytes until it is re-armed. A one-cycle pulse on the clear strobe re-arms it. Software later compares a code taken at read-back with the stored one. Their XOR is the syndrome, which locates a single flipped bit or flags a double error.

Top module: `ecc_stream_gen`

## Requirements
- R1: With `mode_512` low, the code over stream bytes 0..255 is loaded into `code1`, and the code over bytes 256..511 is loaded into `code2`.
- R2: With `mode_512` high, one code over bytes 0..511 is loaded into `code1`, and `code2` keeps its all-ones cleared value.
- R3: A one-cycle `clr_wr` pulse zeroes the byte count and all parities, sets both code registers to all ones and drops `done`. A byte offered in the same cycle as the pulse is discarded.
- R4: Once the final code of the chosen layout is stored, `code1` and `code2` stay unchanged whatever bytes arrive, until the next `clr_wr` pulse.
- R5: When exactly one data bit of a block is flipped, the XOR of the two codes has exactly one bit set in every even/odd pair. The odd members spell out the byte index and the bit index of the flip.
- R6: When two data bits of a block are flipped, the XOR of the codes is nonzero and does not have the single-error pattern.
- R7: Code layout is as follows. For position bit k, bit 2k is the parity of bytes whose position has bit k = 0, and bit 2k+1 is the parity of bytes whose position has bit k = 1. There are 8 position bits for 256 bytes and 9 for 512 bytes. Above these lie three column pairs. For group g = 0, 1, 2, the even member covers data bits whose index has bit g = 0, and the odd member covers data bits whose index has bit g = 1. Every parity bit is stored inverted. In the 256-byte layout, bits 23:22 are 1. A block of all 0xFF bytes therefore yields 24'hFFFFFF.
- R8: The code register loads at the clock edge that accepts the last byte of its block. `done` rises one clock later and stays high until `clr_wr`.
- R9: With `byte_vld` low, `byte_in` has no effect on any code.
- R10: After reset, both codes read 24'hFFFFFF and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_wr | input | 1 | Re-arm strobe, one-cycle pulse |
| mode_512 | input | 1 | 0: two 256-byte codes; 1: one 512-byte code |
| byte_vld | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| code1 | output | 24 | First code register |
| code2 | output | 24 | Second code register |
| done | output | 1 | All codes of the chosen layout stored |

## Verification
A byte sampled at a clock edge shows up in a code register at that same edge if it closes a block, and `done` follows one edge later. The bench therefore drives inputs on the falling edge. It advances its behavioural model on the rising edge and compares the code registers and `done` on the next falling edge. Directed checks sample `code2` one falling edge after the last byte and again one falling edge later, to pin the single-cycle gap before `done`. Syndrome checks read the stored codes only after `done` is high.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;
  localparam int ECC_BLK_BYTES = 256;
  localparam int ECC_AB        = $clog2(ECC_BLK_BYTES);
  localparam int ECC_CW        = ECC_AB + 1;
  localparam int ECC_LPW       = 2 * ECC_CW;
  localparam int ECC_BYTE_W    = 8;
  localparam int ECC_GRP       = $clog2(ECC_BYTE_W);
  localparam int ECC_COLW      = 2 * ECC_GRP;
  localparam int ECC_CODEW     = ECC_COLW + ECC_LPW;
  localparam int ECC_SPARE     = 2;

  // Column parity pairs of an accumulated (XOR of all bytes) value.
  function automatic logic [ECC_COLW-1:0] ecc_col(input logic [ECC_BYTE_W-1:0] x);
    logic [ECC_COLW-1:0] c;
    c = '0;
    for (int b = 0; b < ECC_BYTE_W; b++)
      for (int g = 0; g < ECC_GRP; g++)
        c[2*g + ((b >> g) & 1)] = c[2*g + ((b >> g) & 1)] ^ x[b];
    return c;
  endfunction

  // Assemble the stored (inverted) code from the running parities.
  function automatic logic [ECC_CODEW-1:0] ecc_pack(input logic [ECC_BYTE_W-1:0] xr,
                                                    input logic [ECC_LPW-1:0] lp,
                                                    input logic wide);
    logic [ECC_COLW-1:0] col;
    col = ecc_col(xr);
    if (wide) return ~{col, lp};
    return {{ECC_SPARE{1'b1}}, ~col, ~lp[ECC_LPW-3:0]};
  endfunction
endpackage

// File: rtl/ecc_byte_ctr.sv
module ecc_byte_ctr
  import ecc_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              mode_512,
  output logic [ECC_CW-1:0] cnt,
  output logic              blk_end,
  output logic              fin,
  output logic              frozen
);
  logic last;

  assign last    = &cnt;
  assign blk_end = mode_512 ? last : &cnt[ECC_AB-1:0];
  assign fin     = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      frozen <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      frozen <= 1'b0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (fin) frozen <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_par_acc.sv
module ecc_par_acc
  import ecc_stream_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  take,
  input  logic                  blk_end,
  input  logic [ECC_BYTE_W-1:0] data,
  input  logic [ECC_CW-1:0]     addr,
  output logic [ECC_BYTE_W-1:0] xor_nxt,
  output logic [ECC_LPW-1:0]    lp_nxt
);
  logic [ECC_BYTE_W-1:0] xor_q;
  logic [ECC_LPW-1:0]    lp_q;
  logic                  bpar;

  assign bpar    = ^data;
  assign xor_nxt = xor_q ^ (take ? data : '0);

  for (genvar k = 0; k < ECC_CW; k++) begin : g_line
    assign lp_nxt[2*k]   = lp_q[2*k]   ^ (take & bpar & ~addr[k]);
    assign lp_nxt[2*k+1] = lp_q[2*k+1] ^ (take & bpar &  addr[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xor_q <= '0;
      lp_q  <= '0;
    end else if (clr || (take && blk_end)) begin
      xor_q <= '0;
      lp_q  <= '0;
    end else if (take) begin
      xor_q <= xor_nxt;
      lp_q  <= lp_nxt;
    end
  end
endmodule

// File: rtl/ecc_code_regs.sv
module ecc_code_regs
  import ecc_stream_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 ld1,
  input  logic                 ld2,
  input  logic [ECC_CODEW-1:0] code_in,
  output logic [ECC_CODEW-1:0] code1,
  output logic [ECC_CODEW-1:0] code2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code1 <= '1;
      code2 <= '1;
    end else if (clr) begin
      code1 <= '1;
      code2 <= '1;
    end else begin
      if (ld1) code1 <= code_in;
      if (ld2) code2 <= code_in;
    end
  end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
  import ecc_stream_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_wr,
  input  logic                  mode_512,
  input  logic                  byte_vld,
  input  logic [ECC_BYTE_W-1:0] byte_in,
  output logic [ECC_CODEW-1:0]  code1,
  output logic [ECC_CODEW-1:0]  code2,
  output logic                  done
);
  logic [ECC_CW-1:0]     cnt;
  logic [ECC_CW-1:0]     addr;
  logic                  blk_end, fin, frozen, take, fin_evt, fin_q;
  logic                  ld1, ld2;
  logic [ECC_BYTE_W-1:0] xor_nxt;
  logic [ECC_LPW-1:0]    lp_nxt;
  logic [ECC_CODEW-1:0]  code_nxt;

  assign take     = byte_vld & ~clr_wr & ~frozen;
  assign fin_evt  = take & fin;
  assign addr     = mode_512 ? cnt : {1'b0, cnt[ECC_AB-1:0]};
  assign ld1      = take & blk_end & (mode_512 | ~cnt[ECC_AB]);
  assign ld2      = take & blk_end & ~mode_512 & cnt[ECC_AB];
  assign code_nxt = ecc_pack(xor_nxt, lp_nxt, mode_512);

  ecc_byte_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr_wr), .take(take), .mode_512(mode_512),
    .cnt(cnt), .blk_end(blk_end), .fin(fin), .frozen(frozen)
  );

  ecc_par_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr_wr), .take(take), .blk_end(blk_end),
    .data(byte_in), .addr(addr), .xor_nxt(xor_nxt), .lp_nxt(lp_nxt)
  );

  ecc_code_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr_wr), .ld1(ld1), .ld2(ld2),
    .code_in(code_nxt), .code1(code1), .code2(code2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q <= 1'b0;
      done  <= 1'b0;
    end else if (clr_wr) begin
      fin_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      fin_q <= fin_evt;
      if (fin_q) done <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk
  import ecc_stream_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_wr,
  input logic                 byte_vld,
  input logic                 mode_512,
  input logic                 take,
  input logic                 fin_evt,
  input logic                 ld1,
  input logic                 ld2,
  input logic [ECC_CW-1:0]    cnt,
  input logic [ECC_CODEW-1:0] code1,
  input logic [ECC_CODEW-1:0] code2,
  input logic                 done
);
  a_r1_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld1, ld2}));

  a_r2_code2_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_512) |=> $stable(code2));

  a_r3_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0 && !done && &code1 && &code2));

  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_wr) |=> ($stable(code1) && $stable(code2)));

  a_r8_done_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin_evt, 2));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !clr_wr) |=> ($stable(cnt) && $stable(code1) && $stable(code2)));
endmodule

bind ecc_stream_gen ecc_stream_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .byte_vld(byte_vld),
  .mode_512(mode_512), .take(take), .fin_evt(fin_evt), .ld1(ld1), .ld2(ld2),
  .cnt(cnt), .code1(code1), .code2(code2), .done(done)
);

// File: tb/ecc_stream_gen_tb.sv
module ecc_stream_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_wr = 1'b0;
  logic        mode_512 = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [23:0] code1, code2;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] blk [0:511];

  always #4 clk = ~clk;

  ecc_stream_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .mode_512(mode_512),
    .byte_vld(byte_vld), .byte_in(byte_in), .code1(code1), .code2(code2), .done(done)
  );

  // ---------------- reference computation ----------------
  function automatic logic [23:0] ref_code(input logic [7:0] q[$], input bit wide);
    int nab;
    bit ev_l[9], od_l[9], ev_c[3], od_c[3];
    logic [23:0] c;
    nab = wide ? 9 : 8;
    foreach (ev_l[k]) begin ev_l[k] = 0; od_l[k] = 0; end
    foreach (ev_c[g]) begin ev_c[g] = 0; od_c[g] = 0; end
    for (int i = 0; i < q.size(); i++)
      for (int b = 0; b < 8; b++)
        if (q[i][b]) begin
          for (int k = 0; k < nab; k++)
            if ((i >> k) & 1) od_l[k] = ~od_l[k]; else ev_l[k] = ~ev_l[k];
          for (int g = 0; g < 3; g++)
            if ((b >> g) & 1) od_c[g] = ~od_c[g]; else ev_c[g] = ~ev_c[g];
        end
    c = 24'hFFFFFF;
    for (int k = 0; k < nab; k++) begin
      c[2*k] = ~ev_l[k]; c[2*k+1] = ~od_l[k];
    end
    for (int g = 0; g < 3; g++) begin
      c[2*nab+2*g] = ~ev_c[g]; c[2*nab+2*g+1] = ~od_c[g];
    end
    return c;
  endfunction

  // ---------------- cycle model ----------------
  int          m_cnt;
  bit          m_frozen, m_done, m_fin, m_mode_blk;
  logic [7:0]  m_q[$];
  logic [23:0] m_c1, m_c2;

  initial begin
    m_cnt = 0; m_frozen = 0; m_done = 0; m_fin = 0;
    m_c1 = 24'hFFFFFF; m_c2 = 24'hFFFFFF;
  end

  always @(posedge clk) begin
    if (!rst_n || clr_wr) begin
      m_cnt = 0; m_frozen = 0; m_done = 0; m_fin = 0;
      m_c1 = 24'hFFFFFF; m_c2 = 24'hFFFFFF; m_q.delete();
    end else begin
      if (m_fin) m_done = 1;
      m_fin = 0;
      if (byte_vld && !m_frozen) begin
        m_q.push_back(byte_in);
        m_cnt++;
        if (mode_512 && m_q.size() == 512) begin
          m_c1 = ref_code(m_q, 1); m_frozen = 1; m_fin = 1; m_q.delete();
        end else if (!mode_512 && m_q.size() == 256) begin
          if (m_cnt == 256) m_c1 = ref_code(m_q, 0);
          else begin m_c2 = ref_code(m_q, 0); m_frozen = 1; m_fin = 1; end
          m_q.delete();
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(code1 === m_c1, "R1", "code1 vs model", code1, m_c1);
      chk(code2 === m_c2, "R2", "code2 vs model", code2, m_c2);
      chk(done === m_done, "R8", "done vs model", {23'd0, done}, {23'd0, m_done});
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_clear;
    @(negedge clk); clr_wr = 1'b1;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic stream(input int n, input int gapmod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = blk[i];
      if (gapmod != 0 && ($urandom % gapmod) == 0) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'($urandom);
      end
    end
    @(negedge clk); byte_vld = 1'b0; byte_in = 8'($urandom);
  endtask

  task automatic fill_random;
    for (int i = 0; i < 512; i++) blk[i] = 8'($urandom);
  endtask

  task automatic run_block(input bit m, output logic [23:0] c1, output logic [23:0] c2);
    @(negedge clk); mode_512 = m;
    do_clear();
    stream(512, 0);
    @(negedge clk);
    c1 = code1; c2 = code2;
  endtask

  function automatic logic [23:0] ref_slice(input int lo, input int n, input bit wide);
    logic [7:0] q[$];
    for (int i = lo; i < lo + n; i++) q.push_back(blk[i]);
    return ref_code(q, wide);
  endfunction

  // single-error pattern check: returns 1 if every pair has exactly one bit
  function automatic bit is_single(input logic [23:0] d, input bit wide,
                                   output int idx, output int bitn);
    int nab;
    bit ok;
    nab = wide ? 9 : 8;
    ok = 1; idx = 0; bitn = 0;
    for (int p = 0; p < nab + 3; p++) if (d[2*p] == d[2*p+1]) ok = 0;
    if (!wide && d[23:22] != 2'b00) ok = 0;
    for (int k = 0; k < nab; k++) if (d[2*k+1]) idx += (1 << k);
    for (int g = 0; g < 3; g++) if (d[2*nab+2*g+1]) bitn += (1 << g);
    return ok;
  endfunction

  task automatic flip_test(input bit m, input int pos, input int bitn);
    logic [23:0] a1, a2, b1, b2, d;
    int gi, gb, bpos;
    bit s;
    fill_random();
    run_block(m, a1, a2);
    blk[pos][bitn] = ~blk[pos][bitn];
    run_block(m, b1, b2);
    if (!m && pos >= 256) begin d = a2 ^ b2; bpos = pos - 256; end
    else begin d = a1 ^ b1; bpos = pos; end
    s = is_single(d, m, gi, gb);
    chk(s, "R5", "single flip pattern", d, 24'h0);
    chk(gi == bpos && gb == bitn, "R5", "flip location",
        24'((gi << 3) | gb), 24'((bpos << 3) | bitn));
  endtask

  task automatic dbl_test(input bit m, input int p0, input int b0, input int p1, input int b1);
    logic [23:0] a1, a2, c1, c2, d;
    int gi, gb;
    bit s;
    fill_random();
    run_block(m, a1, a2);
    blk[p0][b0] = ~blk[p0][b0];
    blk[p1][b1] = ~blk[p1][b1];
    run_block(m, c1, c2);
    d = a1 ^ c1;
    s = is_single(d, m, gi, gb);
    chk(d != 24'h0 && !s, "R6", "double flip detected", d, 24'h0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [23:0] e1, e2, h1, h2;
    repeat (3) @(negedge clk);
    chk(code1 === 24'hFFFFFF && code2 === 24'hFFFFFF, "R10", "codes in reset", code1 ^ code2, 24'h0);
    chk(done === 1'b0, "R10", "done in reset", {23'd0, done}, 24'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(code1 === 24'hFFFFFF && done === 1'b0, "R10", "after reset release", code1, 24'hFFFFFF);

    // R1 / R8 / R9: split layout with idle gaps carrying junk bytes
    fill_random();
    @(negedge clk); mode_512 = 1'b0;
    do_clear();
    stream(512, 5);
    e1 = ref_slice(0, 256, 0); e2 = ref_slice(256, 256, 0);
    chk(code1 === e1, "R1", "first block code", code1, e1);
    chk(code2 === e2, "R8", "code2 loaded at last-byte edge", code2, e2);
    chk(done === 1'b0, "R8", "done not yet high", {23'd0, done}, 24'h0);
    @(negedge clk);
    chk(done === 1'b1, "R8", "done one clock later", {23'd0, done}, 24'h1);
    chk(code1 === e1 && code2 === e2, "R9", "junk on idle cycles ignored", code2, e2);

    // R4: bytes after freeze
    fill_random();
    stream(40, 0);
    chk(code1 === e1 && code2 === e2, "R4", "frozen codes", code1, e1);
    chk(done === 1'b1, "R4", "done stays high", {23'd0, done}, 24'h1);

    // R3: clear with a same-cycle byte, then a fresh block
    @(negedge clk); clr_wr = 1'b1; byte_vld = 1'b1; byte_in = 8'h5A;
    @(negedge clk); clr_wr = 1'b0; byte_vld = 1'b0;
    chk(code1 === 24'hFFFFFF && code2 === 24'hFFFFFF, "R3", "codes cleared", code1, 24'hFFFFFF);
    chk(done === 1'b0, "R3", "done cleared", {23'd0, done}, 24'h0);
    fill_random();
    stream(256, 0);
    e1 = ref_slice(0, 256, 0);
    chk(code1 === e1, "R3", "count restarted at zero", code1, e1);
    chk(code2 === 24'hFFFFFF, "R3", "second block pending", code2, 24'hFFFFFF);

    // R2: joined layout
    fill_random();
    run_block(1'b1, h1, h2);
    e1 = ref_slice(0, 512, 1);
    chk(h1 === e1, "R2", "512-byte code", h1, e1);
    chk(h2 === 24'hFFFFFF, "R2", "code2 unused", h2, 24'hFFFFFF);

    // R7: erased blocks
    for (int i = 0; i < 512; i++) blk[i] = 8'hFF;
    run_block(1'b0, h1, h2);
    chk(h1 === 24'hFFFFFF && h2 === 24'hFFFFFF, "R7", "erased split", h1 & h2, 24'hFFFFFF);
    run_block(1'b1, h1, h2);
    chk(h1 === 24'hFFFFFF, "R7", "erased joined", h1, 24'hFFFFFF);

    // R7: single 0x01 at byte 0 gives a known layout
    for (int i = 0; i < 512; i++) blk[i] = 8'h00;
    blk[0] = 8'h01;
    run_block(1'b0, h1, h2);
    // even line bits for all 8 position bits, even column bits for 3 groups
    e1 = ~24'h155555 | 24'hC00000;
    e1 = {2'b11, ~6'b010101, ~16'h5555};
    chk(h1 === e1, "R7", "one-bit layout", h1, e1);

    // R5 / R6: syndrome classification
    flip_test(1'b0, 0, 0);
    flip_test(1'b0, 255, 7);
    flip_test(1'b0, 300, 3);
    flip_test(1'b0, 511, 5);
    flip_test(1'b1, 0, 0);
    flip_test(1'b1, 511, 7);
    flip_test(1'b1, 256, 2);
    flip_test(1'b1, 77, 6);
    dbl_test(1'b0, 10, 1, 10, 2);
    dbl_test(1'b0, 5, 0, 200, 7);
    dbl_test(1'b1, 3, 4, 400, 4);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule